// File: doc/BRIEF.md
# Register-Programmed SPI Word Master

This block is a single-target SPI master that a processor drives through a small 32-bit register bus. Software picks the word length (8 or 16 bits) and the serial clock ratio, then drives the one chip-select line from a control bit. Each write to the transmit register launches one full-duplex word exchange in SPI mode 0. The serial clock idles low. Input data is captured on rising edges and output data changes on falling edges.

When the last bit has moved, a completion flag rises. The received word can then be read back. Software acknowledges the flag by writing zero to it before it launches the next word. A read-only exchange is done by sending a word of zeros.

The serial clock ratio N is any even value from 4 to 30. It is programmed as the 5-bit code 0x10 + N/2.

Top module: `spim_word_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, and the control, configuration and completion registers read 0.
- R2: Bit 0 of the control register (byte offset 0x00) reads back as written. `spi_cs_n` is its inverse.
- R3: The configuration register (offset 0x04) reads back bits [5:0] as written. Bit 5 = 1 selects 16-bit words and bit 5 = 0 selects 8-bit words. Bits [4:0] are the prescale code.
- R4: A prescale code with bit 4 set and bits [3:0] = k ≥ 2 gives a serial clock period of 2k system clocks, high for k and low for k.
- R5: A prescale code with bit 4 clear, or with bits [3:0] below 2, behaves as ratio 4.
- R6: A write to the transmit register (offset 0x08) while idle starts an exchange of B bits (8 or 16). Bits go out MSB first on `spi_mosi` and change only on falling edges. `spi_miso` is sampled on each rising edge. The exchange ends B·N system clocks after the write.
- R7: The completion register (offset 0x10) reads 1 from the cycle after the exchange ends. Writing 0 to it clears it. Completion wins over a clear in the same cycle.
- R8: The receive register (offset 0x0C) returns the word shifted in, MSB first. In 8-bit mode bits [31:8] read 0.
- R9: A write to the transmit register during an exchange is ignored. It neither restarts nor extends the exchange, and it does not alter the bits sent.
- R10: `spi_sclk` is low whenever no exchange is in progress, including between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |

## Verification
A wrong divider count shows up at the ports within the first serial half-period. The high time of `spi_sclk` then differs from N/2, and the total exchange time differs from B·N. A bit counter or width flag in the wrong state shows up by the end of the word. The symptom is a wrong number of rising edges, a shifted or truncated transmit pattern, or nonzero upper receive bits.

A busy flag that drops or restarts wrongly shows up right after an injected mid-word write. It appears as extra clock edges or a late completion flag. A completion flag that fails to set or clear is seen on the next poll of its register.

// File: rtl/spim_pkg.sv
package spim_pkg;
   // register byte offsets on the 5-bit bus address
   localparam logic [4:0] OFF_CTRL  = 5'h00;
   localparam logic [4:0] OFF_CFG   = 5'h04;
   localparam logic [4:0] OFF_TX    = 5'h08;
   localparam logic [4:0] OFF_RX    = 5'h0C;
   localparam logic [4:0] OFF_CAUSE = 5'h10;
   // field positions
   localparam int CS_BIT   = 0;
   localparam int WIDE_BIT = 5;
   localparam int PRESC_W  = 5;
   localparam int CFG_W    = 6;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
   parameter int PRESC_W = 5,
   parameter int CNT_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   localparam int K_W = PRESC_W - 1;

   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] cnt;

   // decode half period; invalid codes fall back to ratio 4
   always_comb begin
      if (presc[PRESC_W-1] && (presc[K_W-1:0] >= K_W'(2)))
         half = CNT_W'(presc[K_W-1:0]);
      else
         half = CNT_W'(2);
   end

   assign tick = en && (cnt == (half - CNT_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!en)     cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + CNT_W'(1);
   end

   // R4
   cnt_below_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt < half));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
   parameter int MAX_BITS = 16,
   parameter int BIT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                wide,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                tick,
   input  logic                miso,
   output logic                busy,
   output logic                done,
   output logic                sclk,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_word
);
   localparam int HALF_BITS = MAX_BITS / 2;

   logic                wide_q;
   logic [BIT_W-1:0]    bit_cnt;
   logic [BIT_W-1:0]    last_bit;
   logic [MAX_BITS-1:0] tx_sh;
   logic [MAX_BITS-1:0] rx_sh;
   logic [MAX_BITS-1:0] tx_aligned;

   assign last_bit = wide_q ? BIT_W'(MAX_BITS - 1) : BIT_W'(HALF_BITS - 1);
   assign done     = busy && tick && sclk && (bit_cnt == last_bit);
   assign mosi     = busy && tx_sh[MAX_BITS-1];

   // narrow words are left-aligned so the MSB leaves first
   assign tx_aligned = wide ? tx_word
                            : {tx_word[HALF_BITS-1:0], {HALF_BITS{1'b0}}};

   generate
      for (genvar i = 0; i < MAX_BITS; i++) begin : g_rx
         if (i < HALF_BITS) begin : g_lo
            assign rx_word[i] = rx_sh[i];
         end else begin : g_hi
            assign rx_word[i] = wide_q & rx_sh[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         wide_q  <= 1'b0;
         bit_cnt <= '0;
         tx_sh   <= '0;
         rx_sh   <= '0;
      end else if (start && !busy) begin
         busy    <= 1'b1;
         sclk    <= 1'b0;
         wide_q  <= wide;
         bit_cnt <= '0;
         tx_sh   <= tx_aligned;
      end else if (busy && tick) begin
         if (!sclk) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[MAX_BITS-2:0], miso};
         end else begin
            sclk <= 1'b0;
            if (bit_cnt == last_bit) begin
               busy <= 1'b0;
            end else begin
               tx_sh   <= {tx_sh[MAX_BITS-2:0], 1'b0};
               bit_cnt <= bit_cnt + BIT_W'(1);
            end
         end
      end
   end

   // R10
   idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
   // R4
   sclk_holds_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !start) |=> $stable(sclk));
   // R6
   mosi_steady_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && !sclk) |=> $stable(mosi));
   // R6
   done_ends_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !sclk));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 5,
   parameter int MAX_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BUS_W-1:0]    bus_wdata,
   output logic [BUS_W-1:0]    bus_rdata,
   input  logic                busy,
   input  logic                done,
   input  logic [MAX_BITS-1:0] rx_word,
   output logic                start,
   output logic [MAX_BITS-1:0] tx_word,
   output logic                wide,
   output logic [PRESC_W-1:0]  presc,
   output logic                cs_on
);
   logic [CFG_W-1:0]    cfg_q;
   logic                cause_q;
   logic [MAX_BITS-1:0] rx_q;
   logic                wr_en;

   assign wr_en   = bus_sel && bus_wr;
   assign start   = wr_en && (bus_addr == ADDR_W'(OFF_TX)) && !busy;
   assign tx_word = bus_wdata[MAX_BITS-1:0];
   assign wide    = cfg_q[WIDE_BIT];
   assign presc   = cfg_q[PRESC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_on   <= 1'b0;
         cfg_q   <= '0;
         cause_q <= 1'b0;
         rx_q    <= '0;
      end else begin
         if (wr_en && bus_addr == ADDR_W'(OFF_CTRL)) cs_on <= bus_wdata[CS_BIT];
         if (wr_en && bus_addr == ADDR_W'(OFF_CFG))  cfg_q <= bus_wdata[CFG_W-1:0];
         if (done) begin
            cause_q <= 1'b1;
            rx_q    <= rx_word;
         end else if (wr_en && bus_addr == ADDR_W'(OFF_CAUSE) && bus_wdata == '0) begin
            cause_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         unique case (bus_addr)
            ADDR_W'(OFF_CTRL):  bus_rdata = BUS_W'(cs_on);
            ADDR_W'(OFF_CFG):   bus_rdata = BUS_W'(cfg_q);
            ADDR_W'(OFF_RX):    bus_rdata = BUS_W'(rx_q);
            ADDR_W'(OFF_CAUSE): bus_rdata = BUS_W'(cause_q);
            default:            bus_rdata = '0;
         endcase
      end
   end

   // R7
   cause_sets_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> cause_q);
   // R7
   cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bus_addr == ADDR_W'(OFF_CAUSE) && bus_wdata == '0 && !done) |=> !cause_q);
endmodule

// File: rtl/spim_word_master.sv
module spim_word_master
   import spim_pkg::*;
#(
   parameter int BUS_W    = 32,
   parameter int ADDR_W   = 5,
   parameter int MAX_BITS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              spi_sclk,
   output logic              spi_cs_n,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int BIT_W = $clog2(MAX_BITS);
   localparam int CNT_W = PRESC_W - 1;

   generate
      if (MAX_BITS != 16) begin : g_bad_bits
         $error("spim_word_master: MAX_BITS must be 16");
      end
      if (BUS_W < MAX_BITS) begin : g_bad_bus
         $error("spim_word_master: BUS_W narrower than a word");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("spim_word_master: ADDR_W too small for the register map");
      end
   endgenerate

   logic                busy, done, tick, start, wide, cs_on;
   logic [MAX_BITS-1:0] tx_word, rx_word;
   logic [PRESC_W-1:0]  presc;

   spim_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .MAX_BITS(MAX_BITS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .done(done), .rx_word(rx_word),
      .start(start), .tx_word(tx_word), .wide(wide), .presc(presc), .cs_on(cs_on)
   );

   spim_clkdiv #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(busy), .presc(presc), .tick(tick)
   );

   spim_shifter #(.MAX_BITS(MAX_BITS), .BIT_W(BIT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .tx_word(tx_word),
      .tick(tick), .miso(spi_miso), .busy(busy), .done(done),
      .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(rx_word)
   );

   assign spi_cs_n = ~cs_on;

   // R9
   busy_write_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/spim_word_master_tb.sv
module spim_word_master_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b1;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = 5'h00;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sclk, spi_cs_n, spi_mosi;
   logic        spi_miso;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [15:0] sl_sh = '0;
   logic [15:0] mosi_cap = '0;
   int          hi_cnt = 0;
   int          rise_cnt = 0;

   always #10 clk = ~clk;

   spim_word_master u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso)
   );

   // target model: presents its MSB and shifts on each falling edge
   assign spi_miso = sl_sh[15];
   always @(negedge spi_sclk) sl_sh <= {sl_sh[14:0], 1'b0};
   always @(posedge spi_sclk) begin
      mosi_cap <= {mosi_cap[14:0], spi_mosi};
      rise_cnt <= rise_cnt + 1;
   end
   always @(negedge clk) if (spi_sclk) hi_cnt <= hi_cnt + 1;

   function automatic int exp_ratio(input logic [4:0] p);
      if (!p[4] || p[3:0] < 4'd2) return 4;
      return 2 * int'(p[3:0]);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic xfer(input bit wide, input logic [4:0] p, input logic [15:0] txw,
                       input logic [15:0] slw, input bit inject);
      int nb, n, cnt, rise0;
      logic [31:0] v;
      logic [15:0] mexp;
      nb = wide ? 16 : 8;
      n  = exp_ratio(p);
      wr(5'h04, {26'd0, wide, p});
      wr(5'h10, 32'd0);
      sl_sh    = wide ? slw : {slw[7:0], 8'h00};
      mosi_cap = '0; hi_cnt = 0; rise_cnt = 0;
      wr(5'h08, {16'hA5A5, txw});
      cnt = 0;
      forever begin
         @(negedge clk);
         cnt++;
         if (inject && cnt == 3 * n) begin
            bus_addr = 5'h08; bus_wdata = {16'h0, ~txw}; bus_wr = 1'b1;
         end else begin
            rd(5'h10, v);
            if (v[0] || cnt > 1000) break;
         end
      end
      // R6 R4 R5: exchange duration is bits * ratio
      check("R6 duration", cnt, nb * n);
      // R4 R5: high time of the serial clock
      check("R4 high cycles", hi_cnt, nb * n / 2);
      check("R6 rising edges", rise_cnt, nb);
      mexp = wide ? txw : {8'h00, txw[7:0]};
      check("R6 mosi bits", wide ? mosi_cap : {8'h00, mosi_cap[7:0]}, mexp);
      rd(5'h0C, v);
      check("R8 rx word", v, wide ? {16'h0, slw} : {24'h0, slw[7:0]});
      check("R10 sclk low after word", spi_sclk, 0);
      if (inject) begin
         rise0 = rise_cnt;
         repeat (3 * n) @(negedge clk);
         // R9: injected write started nothing
         check("R9 no extra edges", rise_cnt, rise0);
         check("R10 sclk stays low", spi_sclk, 0);
      end
      wr(5'h10, 32'd5);
      rd(5'h10, v);
      check("R7 nonzero write keeps flag", v, 1);
      wr(5'h10, 32'd0);
      rd(5'h10, v);
      check("R7 cleared by zero", v, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd1234));
      #1;
      check("R1 cs_n in reset", spi_cs_n, 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cs_n", spi_cs_n, 1);
      check("R1 sclk", spi_sclk, 0);
      check("R1 mosi", spi_mosi, 0);
      rd(5'h00, v); check("R1 ctrl", v, 0);
      rd(5'h04, v); check("R1 cfg", v, 0);
      rd(5'h10, v); check("R1 cause", v, 0);

      wr(5'h00, 32'h1);
      check("R2 cs asserted", spi_cs_n, 0);
      rd(5'h00, v); check("R2 ctrl readback", v, 1);
      wr(5'h00, 32'h0);
      check("R2 cs released", spi_cs_n, 1);
      wr(5'h00, 32'h1);

      wr(5'h04, 32'hFFFF_FF3A);
      rd(5'h04, v); check("R3 cfg readback", v, 32'h3A);

      // directed corners
      xfer(1'b0, 5'h12, 16'h00C3, 16'h005A, 1'b0); // R4 fastest ratio 4
      xfer(1'b1, 5'h1F, 16'hB38E, 16'h71E2, 1'b0); // R4 slowest ratio 30
      xfer(1'b0, 5'h0A, 16'h0081, 16'h00FF, 1'b0); // R5 bit4 clear
      xfer(1'b1, 5'h11, 16'h8001, 16'hC003, 1'b0); // R5 code below ratio 4
      xfer(1'b0, 5'h13, 16'h0000, 16'h003C, 1'b0); // R6 read-only exchange
      xfer(1'b1, 5'h14, 16'hF00D, 16'h1234, 1'b1); // R9 write during exchange
      xfer(1'b0, 5'h15, 16'hFF6B, 16'hAB9D, 1'b1); // R9 R8 8-bit with upper bits

      // random mix
      for (int i = 0; i < 12; i++) begin
         xfer(1'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
      end

      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule